// File: doc/BRIEF.md
# Chainable Center-Aligned PWM Channel

This block is one center-aligned PWM channel. Its time base is a counter that climbs from zero to a programmed period and then falls back to zero, over and over. Two registered outputs are driven from that count. Output A goes high at the bottom of the triangle and low at a compare point on the rising slope. Output B goes high at the top of the triangle and low at a second compare point on the falling slope. The period and both compare values are taken from their input ports only while the counter sits at zero. A new setting therefore never cuts a running cycle short.

Several instances can be chained so that they run with a fixed phase relationship. One channel acts as the master and emits a one-cycle pulse each time its counter is at zero. Each follower forwards the pulse it receives down the chain unchanged. A follower with phase loading enabled passes the incoming pulse through a two-stage register pipe and then forces its counter to a programmed phase value. The whole path from the master's zero to the follower's load is three cycles, so a follower loaded with phase 3 runs exactly in step with its master. A shared run input holds every counter still until configuration is complete, so all channels start together on one clock.

Top module: `pwm_sync_chan`

## Requirements
- R1: While `tb_run` is high, the counter advances by one each cycle as 0,1,…,P,P−1,…,1,0,1,…, so one full cycle lasts 2P clocks, where P is the active period. The first running cycle shows count 0.
- R2: Output A goes to 1 in the cycle after the counter shows 0. It goes to 0 in the cycle after the counter equals compare A while rising, a count of P counting as rising. Otherwise it holds its value.
- R3: Output B goes to 1 in the cycle after the counter equals P. It goes to 0 in the cycle after the counter equals compare B while falling. A count of 0 reached from above counts as falling. The first 0 after start does not count as falling.
- R4: The zero and period actions win over the compare actions. Compare A = 0 keeps A at 1 from the first running cycle on. Compare B = P never clears B once it is set. Compare A = P clears A at the top of the triangle.
- R5: The period, compare A and compare B inputs take effect only at the clock edge that ends a cycle in which the counter is 0. A change made while the counter is away from zero does not alter the cycle in progress.
- R6: With `phase_en` = 1, a pulse on `sync_in` during cycle c makes the counter show `phase_in` in cycle c+3.
- R7: With `phase_en` = 0, pulses on `sync_in` have no effect on the counter.
- R8: After a phase load the counter counts up when `phase_dir_down` = 0 and down when it is 1.
- R9: With `sync_sel` = 0, `sync_out` is 1 exactly in the running cycles in which the counter is 0. With `sync_sel` = 1, `sync_out` equals `sync_in` in the same cycle.
- R10: While `tb_run` is low, the counter and both outputs hold their values. After reset the counter is 0 and both outputs are 0.
- R11: If a master with `sync_sel` = 0 feeds a follower with `phase_en` = 1 and both start on the same cycle, the follower's count lags the master's by exactly 3 cycles when its phase is 0, and equals the master's on every cycle when its phase is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_run | input | 1 | Global time-base enable shared by chained channels |
| period_in | input | CW | Period P, taken at counter zero |
| cmpa_in | input | CW | Compare A, taken at counter zero |
| cmpb_in | input | CW | Compare B, taken at counter zero |
| phase_in | input | CW | Value forced into the counter on a sync load |
| phase_en | input | 1 | 1 = sync pulses load the phase value |
| phase_dir_down | input | 1 | Count direction after a phase load (1 = down) |
| sync_sel | input | 1 | Sync output source: 0 = own zero, 1 = copy of sync_in |
| sync_in | input | 1 | Sync pulse from the previous channel |
| sync_out | output | 1 | Sync pulse to the next channel |
| out_a | output | 1 | PWM output A |
| out_b | output | 1 | PWM output B |
| ctr_out | output | CW | Current time-base count |

## Verification
The assertions check the local rules on every cycle:
- unit steps of the counter;
- the zero-set of A and the period-set of B;
- the freeze of the active period away from zero;
- the value forced by a phase load;
- the hold while stopped;
- the sync pass-through.

Only the bench scenarios can show the longer-range behaviour. These include the exact duty cycle for every pair of compare values at several periods, and the deferral of a new period to the next zero. They also include the three-cycle master-to-follower offset and its cancellation by a phase of 3, and the silence of a follower whose phase loading is off.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
  typedef enum logic {
    SYNC_FROM_ZERO  = 1'b0,
    SYNC_FROM_INPUT = 1'b1
  } sync_src_e;

  // registers between sync_in and the counter load
  localparam int unsigned SYNC_PIPE_DEPTH = 2;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [CW-1:0] prd_in,
  input  logic [CW-1:0] cmpa_in,
  input  logic [CW-1:0] cmpb_in,
  output logic [CW-1:0] prd_act,
  output logic [CW-1:0] cmpa_act,
  output logic [CW-1:0] cmpb_act
);
  // the input ports act as the shadow copy; the active set moves at zero only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act  <= '0;
      cmpa_act <= '0;
      cmpb_act <= '0;
    end else if (take) begin
      prd_act  <= prd_in;
      cmpa_act <= cmpa_in;
      cmpb_act <= cmpb_in;
    end
  end
endmodule

// File: rtl/pwm_sync_path.sv
module pwm_sync_path #(
  parameter int unsigned DEPTH = pwm_sync_pkg::SYNC_PIPE_DEPTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sync_in,
  input  logic                   zero_evt,
  input  pwm_sync_pkg::sync_src_e src,
  output logic                   sync_out,
  output logic                   sync_apply
);
  import pwm_sync_pkg::*;

  logic [DEPTH-1:0] pipe_q;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) pipe_q[0] <= 1'b0;
          else        pipe_q[0] <= sync_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) pipe_q[i] <= 1'b0;
          else        pipe_q[i] <= pipe_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_apply = pipe_q[DEPTH-1];
  assign sync_out   = (src == SYNC_FROM_INPUT) ? sync_in : zero_evt;
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] prd,
  input  logic          load,
  input  logic [CW-1:0] phase,
  input  logic          phase_dir_down,
  output logic [CW-1:0] ctr,
  output logic          cnt_up
);
  localparam logic [CW-1:0] ONE = CW'(1);

  // next {direction_up, count} of the triangle; turns at the period and at zero
  function automatic logic [CW:0] tri_step(input logic [CW-1:0] c,
                                           input logic up,
                                           input logic [CW-1:0] p);
    if (p == '0)   return {1'b1, {CW{1'b0}}};
    if (up) begin
      if (c >= p)  return {1'b0, c - ONE};
      return {1'b1, c + ONE};
    end
    if (c == '0)   return {1'b1, ONE};
    return {1'b0, c - ONE};
  endfunction

  logic [CW:0] nxt;
  assign nxt = tri_step(ctr, cnt_up, prd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctr    <= '0;
      cnt_up <= 1'b1;
    end else if (run) begin
      if (load) begin
        ctr    <= phase;
        cnt_up <= !phase_dir_down;
      end else begin
        ctr    <= nxt[CW-1:0];
        cnt_up <= nxt[CW];
      end
    end
  end
endmodule

// File: rtl/pwm_action.sv
module pwm_action #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] ctr,
  input  logic          cnt_up,
  input  logic [CW-1:0] prd,
  input  logic [CW-1:0] cmpa,
  input  logic [CW-1:0] cmpb,
  output logic          out_a,
  output logic          out_b
);
  // zero event outranks the rising compare
  function automatic logic next_a(input logic cur, input logic [CW-1:0] c,
                                  input logic up, input logic [CW-1:0] ca);
    if (c == '0)        return 1'b1;
    if (up && c == ca)  return 1'b0;
    return cur;
  endfunction

  // period event outranks the falling compare
  function automatic logic next_b(input logic cur, input logic [CW-1:0] c,
                                  input logic up, input logic [CW-1:0] p,
                                  input logic [CW-1:0] cb);
    if (c == p)         return 1'b1;
    if (!up && c == cb) return 1'b0;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (run) begin
      out_a <= next_a(out_a, ctr, cnt_up, cmpa);
      out_b <= next_b(out_b, ctr, cnt_up, prd, cmpb);
    end
  end
endmodule

// File: rtl/pwm_sync_chan.sv
module pwm_sync_chan #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tb_run,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] cmpa_in,
  input  logic [CW-1:0] cmpb_in,
  input  logic [CW-1:0] phase_in,
  input  logic          phase_en,
  input  logic          phase_dir_down,
  input  logic          sync_sel,
  input  logic          sync_in,
  output logic          sync_out,
  output logic          out_a,
  output logic          out_b,
  output logic [CW-1:0] ctr_out
);
  import pwm_sync_pkg::*;

  logic [CW-1:0] tb_ctr;
  logic          tb_up;
  logic [CW-1:0] prd_act, cmpa_act, cmpb_act;
  logic          at_zero;     // counter shows zero (running or not)
  logic          zero_evt;    // running cycle at zero
  logic          sync_apply;  // delayed sync reaching the counter
  logic          load_evt;    // phase value is forced this edge

  assign at_zero  = (tb_ctr == '0);
  assign zero_evt = tb_run && at_zero;
  assign load_evt = tb_run && phase_en && sync_apply;

  pwm_shadow_regs #(.CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .take(at_zero),
    .prd_in(period_in), .cmpa_in(cmpa_in), .cmpb_in(cmpb_in),
    .prd_act(prd_act), .cmpa_act(cmpa_act), .cmpb_act(cmpb_act)
  );

  pwm_sync_path #(.DEPTH(SYNC_PIPE_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .zero_evt(zero_evt),
    .src(sync_src_e'(sync_sel)), .sync_out(sync_out), .sync_apply(sync_apply)
  );

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst_n(rst_n), .run(tb_run), .prd(prd_act),
    .load(load_evt), .phase(phase_in), .phase_dir_down(phase_dir_down),
    .ctr(tb_ctr), .cnt_up(tb_up)
  );

  pwm_action #(.CW(CW)) u_act (
    .clk(clk), .rst_n(rst_n), .run(tb_run), .ctr(tb_ctr), .cnt_up(tb_up),
    .prd(prd_act), .cmpa(cmpa_act), .cmpb(cmpb_act),
    .out_a(out_a), .out_b(out_b)
  );

  assign ctr_out = tb_ctr;
endmodule

// File: rtl/pwm_sync_chan_chk.sv
module pwm_sync_chan_chk #(
  parameter int unsigned CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic [CW-1:0] ctr,
  input logic [CW-1:0] prd_act,
  input logic          at_zero,
  input logic          load_evt,
  input logic [CW-1:0] phase_in,
  input logic          sync_sel,
  input logic          sync_in,
  input logic          sync_out,
  input logic          out_a,
  input logic          out_b
);
  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_evt && prd_act != '0) |=>
      (ctr == $past(ctr) + CW'(1) || ctr == $past(ctr) - CW'(1)));

  assert_zero_sets_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctr == '0) |=> out_a);

  assert_period_sets_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ctr == prd_act) |=> out_b);

  assert_period_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero |=> $stable(prd_act));

  assert_phase_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (ctr == $past(phase_in)));

  assert_sync_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_sel |-> (sync_out == sync_in));

  assert_stopped_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(ctr) && $stable(out_a) && $stable(out_b)));
endmodule

bind pwm_sync_chan pwm_sync_chan_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(tb_run), .ctr(tb_ctr), .prd_act(prd_act),
  .at_zero(at_zero), .load_evt(load_evt), .phase_in(phase_in),
  .sync_sel(sync_sel), .sync_in(sync_in), .sync_out(sync_out),
  .out_a(out_a), .out_b(out_b)
);

// File: tb/sim_pwm_sync_chan.sv
module sim_pwm_sync_chan;
  localparam int CLK_P = 10;
  localparam int CW    = 8;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic rst_n, run;
  logic [CW-1:0] m_prd, m_ca, m_cb, f_phase;
  logic f_pen, f_dir;
  logic m_sync, f_sync, m_a, m_b, f_a, f_b;
  logic [CW-1:0] m_ctr, f_ctr;

  int total = 0;
  int bad   = 0;

  pwm_sync_chan #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .tb_run(run), .period_in(m_prd),
    .cmpa_in(m_ca), .cmpb_in(m_cb), .phase_in(CW'(0)), .phase_en(1'b0),
    .phase_dir_down(1'b0), .sync_sel(1'b0), .sync_in(1'b0),
    .sync_out(m_sync), .out_a(m_a), .out_b(m_b), .ctr_out(m_ctr)
  );

  pwm_sync_chan #(.CW(CW)) u1 (
    .clk(clk), .rst_n(rst_n), .tb_run(run), .period_in(CW'(5)),
    .cmpa_in(CW'(2)), .cmpb_in(CW'(2)), .phase_in(f_phase), .phase_en(f_pen),
    .phase_dir_down(f_dir), .sync_sel(1'b1), .sync_in(m_sync),
    .sync_out(f_sync), .out_a(f_a), .out_b(f_b), .ctr_out(f_ctr)
  );

  function automatic int tri_at(int c, int p);
    int m;
    if (p == 0) return 0;
    m = c % (2*p);
    return (m <= p) ? m : 2*p - m;
  endfunction

  function automatic int want_a(int c, int p, int ca);
    if (c == 0) return 0;
    if (ca == 0) return 1;
    return (((c-1) % (2*p)) < ca) ? 1 : 0;
  endfunction

  function automatic int want_b(int c, int p, int cb);
    int n;
    if (c == 0) return 0;
    n = c - 1;
    if (n < p) return 0;
    if (cb == p) return 1;
    return (((n-p) % (2*p)) < (p-cb)) ? 1 : 0;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
    end
  endtask

  // reset both channels, let shadows settle, then start on the next edge
  task automatic restart(input int p, input int ca, input int cb);
    @(posedge clk); #1;
    rst_n = 1'b0; run = 1'b0;
    m_prd = CW'(p); m_ca = CW'(ca); m_cb = CW'(cb);
    repeat (2) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;
    run = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; run = 1'b0;
    m_prd = '0; m_ca = '0; m_cb = '0;
    f_phase = '0; f_pen = 1'b0; f_dir = 1'b0;

    // R10: reset state and hold while stopped
    restart(5, 2, 3);
    run = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk("R10 ctr idle", int'(m_ctr), 0);
      chk("R10 out_a idle", int'(m_a), 0);
      chk("R10 out_b idle", int'(m_b), 0);
    end

    // R1..R4: sweep periods and every compare pair
    for (int p = 1; p <= 6; p++)
      for (int ca = 0; ca <= p; ca++)
        for (int cb = 0; cb <= p; cb++) begin
          restart(p, ca, cb);
          for (int c = 0; c < 4*p + 2; c++) begin
            @(negedge clk);
            chk("R1 triangle", int'(m_ctr), tri_at(c, p));
            chk((ca == 0 || ca == p) ? "R4 out_a" : "R2 out_a",
                int'(m_a), want_a(c, p, ca));
            chk((cb == 0 || cb == p) ? "R4 out_b" : "R3 out_b",
                int'(m_b), want_b(c, p, cb));
          end
        end

    // R5: period change mid-cycle waits for zero
    restart(5, 2, 3);
    for (int c = 0; c <= 16; c++) begin
      @(negedge clk);
      chk("R5 deferred period", int'(m_ctr), (c <= 10) ? tri_at(c, 5) : tri_at(c-10, 3));
      if (c == 2) m_prd = CW'(3);
    end

    // R10: pause mid-run
    restart(5, 4, 3);
    repeat (3) @(negedge clk);
    @(posedge clk); #1 run = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R10 paused ctr", int'(m_ctr), 3);
      chk("R10 paused out_a", int'(m_a), 1);
    end
    @(posedge clk); #1 run = 1'b1;
    @(negedge clk); chk("R10 resume ctr", int'(m_ctr), 3);
    @(negedge clk); chk("R10 resume ctr", int'(m_ctr), 4);

    // R6 R11 R9: follower phase 0 lags by three
    f_pen = 1'b1; f_phase = CW'(0); f_dir = 1'b0;
    restart(5, 2, 3);
    for (int c = 0; c <= 30; c++) begin
      @(negedge clk);
      chk("R11 master ctr", int'(m_ctr), tri_at(c, 5));
      chk("R6 R11 follower lag", int'(f_ctr), (c < 3) ? c : tri_at(c-3, 5));
      chk("R9 zero pulse", int'(m_sync), (c % 10 == 0) ? 1 : 0);
      chk("R9 pass copy", int'(f_sync), int'(m_sync));
    end

    // R11: follower phase 3 in step
    f_phase = CW'(3);
    restart(5, 2, 3);
    for (int c = 0; c <= 30; c++) begin
      @(negedge clk);
      chk("R11 aligned", int'(f_ctr), int'(m_ctr));
    end

    // R7: loading disabled, sync ignored
    f_pen = 1'b0; f_phase = CW'(2);
    restart(5, 2, 3);
    for (int c = 0; c <= 30; c++) begin
      @(negedge clk);
      chk("R7 no load", int'(f_ctr), tri_at(c, 5));
    end

    // R8: count down after load
    f_pen = 1'b1; f_phase = CW'(3); f_dir = 1'b1;
    restart(5, 2, 3);
    for (int c = 0; c <= 6; c++) begin
      @(negedge clk);
      if (c >= 3) chk("R8 down after load", int'(f_ctr), 6 - c);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule